// File: doc/BRIEF.md
# Reset Hold Timer and Halt Controller

This block sits beside an 8-bit microcontroller core and controls two things: the core reset and the enable of the CPU clock. Three events start a one-shot hold timer: the power supply coming good, a recovery from stop mode, or a watchdog timeout. While the timer runs, the core is held in reset. The timer counts rising edges of a separate slow clock. That slow clock is sampled into the main clock domain, so all of the state lives in one domain. A stop-mode register bit lets stop recovery skip the hold and resume at once. Power-good and watchdog events always run the full hold.

The same block runs the halt state. When the core requests halt at an instruction boundary, the CPU clock enable drops. The oscillator, the timers and the interrupt sources keep running. Only an interrupt request whose enable bit is set brings the core back. Any reset event clears halt, and reset wins over a halt request that arrives in the same cycle.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After the synchronous reset input, `core_rst` is 1 and `cpu_clk_en` is 1. With power good, `core_rst` is released after one full hold interval.
- R2: The hold lasts `HOLD_TICKS` rising edges of `rc_clk`, counted after the last trigger. `core_rst` drops on the main-clock cycle after the final counted edge.
- R3: While `pwr_ok` is 0, `core_rst` stays 1. A 0-to-1 change of `pwr_ok` starts a full hold.
- R4: A rising edge on `wdt_expire` starts a full hold.
- R5: A rising edge on `stop_wake` while `stop_skip` is 0 starts a full hold.
- R6: A rising edge on `stop_wake` while `stop_skip` is 1 leaves `core_rst` at 0.
- R7: `stop_skip` has no effect on watchdog or power-good holds. These still run the full interval.
- R8: A trigger that arrives during a running hold restarts the count from zero.
- R9: `cpu_clk_en` drops one cycle after `halt_req` and `insn_boundary` are both 1. A `halt_req` without `insn_boundary` is ignored.
- R10: In halt, the clock enable returns one cycle after a request on an `irq_req` bit whose `irq_en` bit is 1. A request on a masked bit keeps the core halted.
- R11: Any reset trigger clears halt, so `cpu_clk_en` returns to 1.
- R12: While `core_rst` is 1, a halt request is refused and `cpu_clk_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_clk | input | 1 | Slow free-running clock that times the hold |
| pwr_ok | input | 1 | Supply good level, asynchronous |
| stop_wake | input | 1 | Stop-mode recovery event, asynchronous |
| wdt_expire | input | 1 | Watchdog timeout, asynchronous |
| stop_skip | input | 1 | Stop-mode register bit 5: 1 skips the hold on stop recovery |
| halt_req | input | 1 | Core asks to halt |
| insn_boundary | input | 1 | Core is between instructions |
| irq_req | input | NIRQ | Interrupt requests |
| irq_en | input | NIRQ | Interrupt enables, one per request |
| core_rst | output | 1 | Reset to the core, registered |
| cpu_clk_en | output | 1 | CPU clock enable, registered |

## Verification
Two functions can meet in one cycle: a reset event and a halt entry. The first case is provoked by driving `halt_req` with `insn_boundary` while a watchdog hold is running. The clock enable must stay 1 through the request. The second case pulses the watchdog while the core is halted. The bench expects `core_rst` to be 1 and `cpu_clk_en` to be back at 1 a few cycles later, after the synchroniser delay.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef struct packed {
    logic pwr;
    logic stop;
    logic wdt;
  } trig_t;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rc_tick.sv
module rc_tick (
  input  logic clk,
  input  logic rst,
  input  logic rc_clk,
  output logic tick
);
  logic rc_s, rc_prev;
  sync2 #(.W(1)) u_sync (.clk(clk), .rst(rst), .d(rc_clk), .q(rc_s));
  always_ff @(posedge clk) begin
    if (rst) rc_prev <= 1'b0;
    else     rc_prev <= rc_s;
  end
  assign tick = rc_s & ~rc_prev;
endmodule

// File: rtl/hold_oneshot.sv
module hold_oneshot #(
  parameter int HOLD_TICKS = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  output logic core_rst
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      core_rst <= 1'b1;
    end else if (clear) begin
      cnt      <= '0;
      core_rst <= 1'b1;
    end else if (core_rst && tick) begin
      if (cnt == LAST) begin
        cnt      <= '0;
        core_rst <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_trigger_holds_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (core_rst && cnt == '0));
  assert_release_on_last_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> ($past(cnt) == LAST && $past(tick)));
  assert_count_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !core_rst |-> cnt == '0);
endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl #(
  parameter int NIRQ = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rst_hold,
  input  logic            halt_req,
  input  logic            insn_boundary,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            cpu_clk_en
);
  logic halted, halted_nxt, wake;
  assign wake = |(irq_req & irq_en);

  always_comb begin
    if (rst_hold)    halted_nxt = 1'b0;
    else if (halted) halted_nxt = ~wake;
    else             halted_nxt = halt_req & insn_boundary & ~wake;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halted     <= 1'b0;
      cpu_clk_en <= 1'b1;
    end else begin
      halted     <= halted_nxt;
      cpu_clk_en <= ~halted_nxt;
    end
  end

  assert_reset_clears_halt_R11: assert property (@(posedge clk) disable iff (rst)
    rst_hold |=> cpu_clk_en);
  assert_masked_stays_R10: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && !wake && !rst_hold) |=> !cpu_clk_en);
  assert_enabled_wakes_R10: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && wake) |=> cpu_clk_en);
  assert_entry_at_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && !(halt_req && insn_boundary)) |=> cpu_clk_en);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int HOLD_TICKS = 2500,
  parameter int NIRQ       = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rc_clk,
  input  logic            pwr_ok,
  input  logic            stop_wake,
  input  logic            wdt_expire,
  input  logic            stop_skip,
  input  logic            halt_req,
  input  logic            insn_boundary,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            core_rst,
  output logic            cpu_clk_en
);
  trig_t raw, synced, prev;
  logic  tick, stop_edge, wdt_edge, clear;

  assign raw = '{pwr: pwr_ok, stop: stop_wake, wdt: wdt_expire};

  sync2 #(.W($bits(trig_t))) u_trig_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= synced;
  end

  assign stop_edge = synced.stop & ~prev.stop;
  assign wdt_edge  = synced.wdt  & ~prev.wdt;
  // Power fail holds the timer at zero; the good edge lets it count.
  assign clear = ~synced.pwr | wdt_edge | (stop_edge & ~stop_skip);

  rc_tick u_tick (.clk(clk), .rst(rst), .rc_clk(rc_clk), .tick(tick));

  hold_oneshot #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(rst), .tick(tick), .clear(clear), .core_rst(core_rst)
  );

  halt_ctrl #(.NIRQ(NIRQ)) u_halt (
    .clk(clk), .rst(rst), .rst_hold(clear | core_rst),
    .halt_req(halt_req), .insn_boundary(insn_boundary),
    .irq_req(irq_req), .irq_en(irq_en), .cpu_clk_en(cpu_clk_en)
  );

  assert_no_halt_in_reset_R12: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> cpu_clk_en);
  assert_skip_no_reset_R6: assert property (@(posedge clk) disable iff (rst)
    (!core_rst && synced.pwr && !wdt_edge && stop_skip) |=> !core_rst);
endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int HOLD = 16;
  localparam int RCH  = 4;
  localparam int LO   = HOLD * 2 * RCH - 6;
  localparam int HI   = HOLD * 2 * RCH + 8;

  logic clk = 0, rst = 1, rc_clk = 0;
  logic pwr_ok = 1, stop_wake = 0, wdt_expire = 0, stop_skip = 0;
  logic halt_req = 0, insn_boundary = 0;
  logic [2:0] irq_req = 0, irq_en = 0;
  logic core_rst, cpu_clk_en;
  int checks = 0, failures = 0;

  typedef struct { string req; int sig; logic val; } exp_t;
  exp_t exp_q[$];

  pwr_seq_ctrl #(.HOLD_TICKS(HOLD), .NIRQ(3)) dut (
    .clk(clk), .rst(rst), .rc_clk(rc_clk), .pwr_ok(pwr_ok),
    .stop_wake(stop_wake), .wdt_expire(wdt_expire), .stop_skip(stop_skip),
    .halt_req(halt_req), .insn_boundary(insn_boundary),
    .irq_req(irq_req), .irq_en(irq_en),
    .core_rst(core_rst), .cpu_clk_en(cpu_clk_en)
  );

  always #10 clk = ~clk;

  initial forever begin
    repeat (RCH) @(posedge clk);
    #1 rc_clk = ~rc_clk;
  end

  // monitor: sig 0 = core_rst, sig 1 = cpu_clk_en
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      logic act;
      e = exp_q.pop_front();
      act = (e.sig == 0) ? core_rst : cpu_clk_en;
      checks++;
      if (act !== e.val) begin
        failures++;
        $display("FAIL %s sig%0d actual=%b expected=%b", e.req, e.sig, act, e.val);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string req, int sig, logic val);
    exp_q.push_back('{req, sig, val});
  endtask

  task automatic measure(string req, int start);
    int n = start;
    while (core_rst && n < 2000) begin
      step(1);
      n++;
    end
    checks++;
    if (n < LO || n > HI) begin
      failures++;
      $display("FAIL %s hold cycles actual=%0d expected=%0d..%0d", req, n, LO, HI);
    end
  endtask

  task automatic pulse_wdt();
    wdt_expire = 1; step(3); wdt_expire = 0;
  endtask

  task automatic pulse_stop();
    stop_wake = 1; step(3); stop_wake = 0;
  endtask

  initial begin
    step(3);
    expect_out("R1", 0, 1'b1);
    expect_out("R1", 1, 1'b1);
    rst = 0;
    measure("R1", 0);
    step(2);
    expect_out("R1", 0, 1'b0);

    pulse_wdt();
    measure("R4", 3);
    step(4);

    stop_skip = 0;
    pulse_stop();
    measure("R5", 3);
    step(4);

    stop_skip = 1;
    pulse_stop();
    step(12);
    expect_out("R6", 0, 1'b0);
    step(1);

    pulse_wdt();
    measure("R7", 3);
    step(4);
    stop_skip = 0;

    pwr_ok = 0;
    step(200);
    expect_out("R3", 0, 1'b1);
    pwr_ok = 1;
    measure("R3", 0);
    step(4);

    pulse_wdt();
    step(60);
    pulse_wdt();
    measure("R8", 3);
    step(4);

    halt_req = 1; insn_boundary = 0;
    step(1);
    expect_out("R9", 1, 1'b1);
    insn_boundary = 1;
    step(1);
    halt_req = 0; insn_boundary = 0;
    expect_out("R9", 1, 1'b0);
    step(1);
    irq_req = 3'b010; irq_en = 3'b101;
    step(2);
    expect_out("R10", 1, 1'b0);
    irq_en = 3'b011;
    step(1);
    expect_out("R10", 1, 1'b1);
    irq_req = 0; irq_en = 0;
    step(1);

    halt_req = 1; insn_boundary = 1;
    step(1);
    halt_req = 0; insn_boundary = 0;
    expect_out("R11", 1, 1'b0);
    step(1);
    pulse_wdt();
    step(2);
    expect_out("R11", 0, 1'b1);
    expect_out("R11", 1, 1'b1);
    step(1);
    halt_req = 1; insn_boundary = 1;
    step(2);
    expect_out("R12", 1, 1'b1);
    step(1);
    halt_req = 0; insn_boundary = 0;
    measure("R2", 8);
    step(2);
    expect_out("R2", 0, 1'b0);
    expect_out("R12", 1, 1'b1);
    step(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule